// File: doc/BRIEF.md
# Boot Status LED Flash Encoder

This block remembers the most recent boot-progress code that a host wrote to it. When a failure is reported, it lights a red LED steadily and blinks the remembered code on a status LED. The code is shown as a fixed number of base-5 digits, most significant digit first. A zero digit is shown as one long flash. A nonzero digit is shown as that many short flashes. A pause follows every digit. After the last digit and a final wait, the red LED changes from steady to blinking, so the failure stays visible after playback has ended.

All timing is counted in periods of an external millisecond tick, which is a single-cycle pulse. The block never counts raw clock cycles, so it works at any system clock rate. Every duration is a parameter. The defaults are 1000 ms for the long flash, 100 ms for a short flash, 200 ms for the dark gap after any flash, 700 ms for the extra pause after each digit, 1000 ms for the final wait, and 500 ms for each half-period of the red blink.

A failure can be reported in two ways: by pulsing a dedicated request input, or by writing the reserved failure value (all ones) to the code port. While playback is running, the busy output is high and further failure reports are ignored.

Top module: `boot_flash_encoder`

## Requirements
- R1: After synchronous reset, status_led, red_led and busy are low, and the stored code is 0, so a first failure report plays three long flashes.
- R2: A code write whose value is not the failure value (all ones, 255 by default) replaces the stored code. A write of the failure value leaves the stored code unchanged and counts as a failure report.
- R3: A failure report while busy is low sets busy and red_led high from the next clock edge. Playback uses the code stored before that edge. Code writes made during playback do not change the sequence being shown.
- R4: The code is shown as NUM_DIGITS digits, most significant first. Digit k equals floor(code / RADIX^k) mod RADIX.
- R5: A zero digit lights status_led for ZERO_ON_MS ticks, then keeps it dark for GAP_MS ticks.
- R6: A nonzero digit d produces d flashes. Each flash lights status_led for SHORT_ON_MS ticks, then keeps it dark for GAP_MS ticks.
- R7: Every digit is followed by an extra DIGIT_PAUSE_MS ticks with status_led dark.
- R8: After the last digit's pause, status_led stays dark for FINAL_WAIT_MS more ticks. Then busy falls and red_led starts blinking: it stays on for BLINK_HALF_MS ticks, then toggles every BLINK_HALF_MS ticks until reset or the next playback.
- R9: Each interval of N ticks ends at the clock edge that samples the Nth tick. During playback, the outputs change only at edges that sample a tick.
- R10: While busy is high, failure reports are ignored, whether they come from fail_req or from a write of the failure value.
- R11: A failure report during the red blinking phase starts a new playback, with red_led steady on from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| code_wr_en | input | 1 | Write strobe for the code port |
| code_wr_data | input | CODE_W | Code value; all ones is the failure value |
| fail_req | input | 1 | Single-cycle failure report |
| ms_tick | input | 1 | Single-cycle millisecond tick |
| status_led | output | 1 | Digit flash output, high means lit |
| red_led | output | 1 | Red failure indicator, high means lit |
| busy | output | 1 | High from playback start until red blinking begins |

## Verification
The assertions assume a few things about the inputs. ms_tick is a single-cycle pulse. Every duration parameter is at least one tick. A normal code write and a failure report never arrive in the same cycle. Under these assumptions, phase changes happen only on tick-sampling edges, and reports made while busy cannot stop playback.

The stimulus follows the same rules. Each tick is a one-cycle pulse followed by a random number of idle cycles. Random code writes are placed in cycles without a tick. Failure reports injected during playback ride on tick cycles, so the check that they are ignored also exercises the phase boundaries.

// File: rtl/blf_pkg.sv
package blf_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LIT,
        SQ_DARK,
        SQ_PAUSE,
        SQ_FINAL,
        SQ_BLINK
    } seq_state_e;

    typedef enum logic [1:0] {
        RM_OFF,
        RM_STEADY,
        RM_BLINK
    } red_mode_e;

    // Digit at position pos (0 = least significant) of value in base radix.
    function automatic int unsigned digit_at(input int unsigned value,
                                             input int unsigned pos,
                                             input int unsigned radix);
        int unsigned v;
        v = value;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(pos)) v = v / radix;
        end
        return v % radix;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/blf_code_store.sv
module blf_code_store #(
    parameter int unsigned  CODE_W    = 8,
    parameter logic [CODE_W-1:0] FAIL_CODE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [CODE_W-1:0] wr_data_i,
    output logic [CODE_W-1:0] stored_o,
    output logic              fail_wr_o
);

    logic [CODE_W-1:0] stored_q;

    assign fail_wr_o = wr_en_i && (wr_data_i == FAIL_CODE);
    assign stored_o  = stored_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
        end else if (wr_en_i && !fail_wr_o) begin
            stored_q <= wr_data_i;
        end
    end

    AST_FAIL_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        fail_wr_o |=> $stable(stored_q)); // R2

endmodule

// File: rtl/blf_tick_timer.sv
module blf_tick_timer #(
    parameter int unsigned TW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          done_o
);

    logic [TW-1:0] cnt_q;

    // Interval of N ticks finishes on the edge that samples the Nth tick.
    assign done_o = tick_i && (cnt_q == TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    AST_TIMER_SETTLES: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i) |=> (cnt_q == '0)); // R9

    AST_TIMER_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (load_val_i != '0)); // R9

endmodule

// File: rtl/blf_playback_seq.sv
module blf_playback_seq
    import blf_pkg::*;
#(
    parameter int unsigned CODE_W         = 8,
    parameter int unsigned RADIX          = 5,
    parameter int unsigned NUM_DIGITS     = 3,
    parameter int unsigned DIG_W          = 3,
    parameter int unsigned IDX_W          = 2,
    parameter int unsigned TW             = 10,
    parameter int unsigned ZERO_ON_MS     = 1000,
    parameter int unsigned SHORT_ON_MS    = 100,
    parameter int unsigned GAP_MS         = 200,
    parameter int unsigned DIGIT_PAUSE_MS = 700,
    parameter int unsigned FINAL_WAIT_MS  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              tick_i,
    output logic              status_led_o,
    output logic              busy_o,
    output logic              blink_go_o
);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DIG_W-1:0]  left_q, left_d;
    logic [DIG_W-1:0]  digits_q [NUM_DIGITS];

    logic              t_load;
    logic [TW-1:0]     t_val;
    logic              t_done;

    logic              accept;
    logic              enter;
    logic [DIG_W-1:0]  enter_dig;
    logic [DIG_W-1:0]  first_dig;

    assign accept    = start_i && ((state_q == SQ_IDLE) || (state_q == SQ_BLINK));
    assign first_dig = DIG_W'(digit_at(32'(code_i), NUM_DIGITS - 1, RADIX));

    blf_tick_timer #(.TW(TW)) u_phase_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (t_load),
        .load_val_i (t_val),
        .tick_i     (tick_i),
        .done_o     (t_done)
    );

    always_comb begin
        state_d    = state_q;
        idx_d      = idx_q;
        left_d     = left_q;
        t_load     = 1'b0;
        t_val      = '0;
        blink_go_o = 1'b0;
        enter      = 1'b0;
        enter_dig  = '0;
        unique case (state_q)
            SQ_IDLE, SQ_BLINK: begin
                if (accept) begin
                    idx_d     = IDX_W'(NUM_DIGITS - 1);
                    enter     = 1'b1;
                    enter_dig = first_dig;
                end
            end
            SQ_LIT: begin
                if (t_done) begin
                    state_d = SQ_DARK;
                    t_load  = 1'b1;
                    t_val   = TW'(GAP_MS);
                end
            end
            SQ_DARK: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (left_q > DIG_W'(1)) begin
                        left_d  = left_q - DIG_W'(1);
                        state_d = SQ_LIT;
                        t_val   = TW'(SHORT_ON_MS);
                    end else begin
                        state_d = SQ_PAUSE;
                        t_val   = TW'(DIGIT_PAUSE_MS);
                    end
                end
            end
            SQ_PAUSE: begin
                if (t_done) begin
                    if (idx_q == '0) begin
                        state_d = SQ_FINAL;
                        t_load  = 1'b1;
                        t_val   = TW'(FINAL_WAIT_MS);
                    end else begin
                        idx_d     = idx_q - IDX_W'(1);
                        enter     = 1'b1;
                        enter_dig = digits_q[idx_q - IDX_W'(1)];
                    end
                end
            end
            SQ_FINAL: begin
                if (t_done) begin
                    state_d    = SQ_BLINK;
                    blink_go_o = 1'b1;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
        if (enter) begin
            state_d = SQ_LIT;
            t_load  = 1'b1;
            if (enter_dig == '0) begin
                left_d = '0;
                t_val  = TW'(ZERO_ON_MS);
            end else begin
                left_d = enter_dig;
                t_val  = TW'(SHORT_ON_MS);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            left_q  <= '0;
            for (int k = 0; k < NUM_DIGITS; k++) digits_q[k] <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            left_q  <= left_d;
            if (accept) begin
                for (int k = 0; k < NUM_DIGITS; k++) begin
                    digits_q[k] <= DIG_W'(digit_at(32'(code_i), k, RADIX));
                end
            end
        end
    end

    assign status_led_o = (state_q == SQ_LIT);
    assign busy_o       = (state_q != SQ_IDLE) && (state_q != SQ_BLINK);

    AST_LIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_LIT && !tick_i) |=> (state_q == SQ_LIT)); // R9

    AST_FLASH_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (left_q <= DIG_W'(RADIX - 1))); // R6

    AST_DIGIT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_PAUSE && t_done && idx_q != '0) |=> (idx_q == $past(idx_q) - IDX_W'(1))); // R4

endmodule

// File: rtl/blf_red_ctrl.sv
module blf_red_ctrl
    import blf_pkg::*;
#(
    parameter int unsigned TW            = 10,
    parameter int unsigned BLINK_HALF_MS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic blink_go_i,
    input  logic tick_i,
    output logic red_o
);

    red_mode_e mode_q;
    logic      red_q;
    logic      t_load;
    logic      t_done;

    assign t_load = blink_go_i || ((mode_q == RM_BLINK) && t_done && !start_i);

    blf_tick_timer #(.TW(TW)) u_blink_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (t_load),
        .load_val_i (TW'(BLINK_HALF_MS)),
        .tick_i     (tick_i),
        .done_o     (t_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RM_OFF;
            red_q  <= 1'b0;
        end else if (start_i) begin
            mode_q <= RM_STEADY;
            red_q  <= 1'b1;
        end else if (blink_go_i) begin
            mode_q <= RM_BLINK;
        end else if ((mode_q == RM_BLINK) && t_done) begin
            red_q <= !red_q;
        end
    end

    assign red_o = red_q;

    AST_RED_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mode_q == RM_BLINK && !tick_i && !start_i) |=> $stable(red_q)); // R8

endmodule

// File: rtl/boot_flash_encoder.sv
module boot_flash_encoder
    import blf_pkg::*;
#(
    parameter int unsigned CODE_W         = 8,
    parameter int unsigned RADIX          = 5,
    parameter int unsigned NUM_DIGITS     = 3,
    parameter int unsigned ZERO_ON_MS     = 1000,
    parameter int unsigned SHORT_ON_MS    = 100,
    parameter int unsigned GAP_MS         = 200,
    parameter int unsigned DIGIT_PAUSE_MS = 700,
    parameter int unsigned FINAL_WAIT_MS  = 1000,
    parameter int unsigned BLINK_HALF_MS  = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_wr_en,
    input  logic [CODE_W-1:0] code_wr_data,
    input  logic              fail_req,
    input  logic              ms_tick,
    output logic              status_led,
    output logic              red_led,
    output logic              busy
);

    localparam int unsigned DIG_W   = (RADIX > 2) ? $clog2(RADIX) : 1;
    localparam int unsigned IDX_W   = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam int unsigned MAX_DUR = max_u(max_u(max_u(ZERO_ON_MS, SHORT_ON_MS),
                                                  max_u(GAP_MS, DIGIT_PAUSE_MS)),
                                            max_u(FINAL_WAIT_MS, BLINK_HALF_MS));
    localparam int unsigned TW      = $clog2(MAX_DUR + 1);

    logic [CODE_W-1:0] stored;
    logic              fail_wr;
    logic              fail_any;
    logic              start;
    logic              blink_go;

    blf_code_store #(
        .CODE_W    (CODE_W),
        .FAIL_CODE ({CODE_W{1'b1}})
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (code_wr_en),
        .wr_data_i (code_wr_data),
        .stored_o  (stored),
        .fail_wr_o (fail_wr)
    );

    assign fail_any = fail_req || fail_wr;
    assign start    = fail_any && !busy;

    blf_playback_seq #(
        .CODE_W         (CODE_W),
        .RADIX          (RADIX),
        .NUM_DIGITS     (NUM_DIGITS),
        .DIG_W          (DIG_W),
        .IDX_W          (IDX_W),
        .TW             (TW),
        .ZERO_ON_MS     (ZERO_ON_MS),
        .SHORT_ON_MS    (SHORT_ON_MS),
        .GAP_MS         (GAP_MS),
        .DIGIT_PAUSE_MS (DIGIT_PAUSE_MS),
        .FINAL_WAIT_MS  (FINAL_WAIT_MS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .code_i       (stored),
        .tick_i       (ms_tick),
        .status_led_o (status_led),
        .busy_o       (busy),
        .blink_go_o   (blink_go)
    );

    blf_red_ctrl #(
        .TW            (TW),
        .BLINK_HALF_MS (BLINK_HALF_MS)
    ) u_red (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .blink_go_i (blink_go),
        .tick_i     (ms_tick),
        .red_o      (red_led)
    );

    AST_BUSY_RED: assert property (@(posedge clk) disable iff (rst)
        busy |-> red_led); // R3

    AST_START_LIGHTS_RED: assert property (@(posedge clk) disable iff (rst)
        (!busy && fail_any) |=> (busy && red_led)); // R3

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && fail_any && !ms_tick) |=> busy); // R10

endmodule

// File: tb/boot_flash_encoder_tb_top.sv
`timescale 1ns/1ps
module boot_flash_encoder_tb_top;

    localparam int L_ON  = 6;
    localparam int S_ON  = 2;
    localparam int GAP   = 3;
    localparam int PAUSE = 4;
    localparam int FINAL = 5;
    localparam int BLINK = 3;
    localparam logic [7:0] FAIL_V = 8'hFF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_wr_en = 1'b0;
    logic [7:0] code_wr_data = '0;
    logic       fail_req = 1'b0;
    logic       ms_tick = 1'b0;
    logic       status_led, red_led, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int model_code = 0;

    always #2.5 clk = ~clk;

    boot_flash_encoder #(
        .CODE_W (8), .RADIX (5), .NUM_DIGITS (3),
        .ZERO_ON_MS (L_ON), .SHORT_ON_MS (S_ON), .GAP_MS (GAP),
        .DIGIT_PAUSE_MS (PAUSE), .FINAL_WAIT_MS (FINAL), .BLINK_HALF_MS (BLINK)
    ) dut_i (
        .clk (clk), .rst (rst), .code_wr_en (code_wr_en), .code_wr_data (code_wr_data),
        .fail_req (fail_req), .ms_tick (ms_tick),
        .status_led (status_led), .red_led (red_led), .busy (busy)
    );

    // Expected {busy, red, status} after s ticks since playback start (R4..R9).
    function automatic logic [2:0] exp_slot(input int code, input int s);
        int t = 0;
        int d;
        int dv;
        for (int k = 2; k >= 0; k--) begin
            dv = (k == 2) ? 25 : ((k == 1) ? 5 : 1);
            d  = (code / dv) % 5;
            if (d == 0) begin
                if (s < t + L_ON) return 3'b111;
                t += L_ON;
                if (s < t + GAP) return 3'b110;
                t += GAP;
            end else begin
                for (int j = 0; j < d; j++) begin
                    if (s < t + S_ON) return 3'b111;
                    t += S_ON;
                    if (s < t + GAP) return 3'b110;
                    t += GAP;
                end
            end
            if (s < t + PAUSE) return 3'b110;
            t += PAUSE;
        end
        if (s < t + FINAL) return 3'b110;
        t += FINAL;
        return {1'b0, (((s - t) / BLINK) % 2) == 0, 1'b0};
    endfunction

    function automatic int total_len(input int code);
        int t = 0;
        int d;
        int dv;
        for (int k = 2; k >= 0; k--) begin
            dv = (k == 2) ? 25 : ((k == 1) ? 5 : 1);
            d  = (code / dv) % 5;
            if (d == 0) t += L_ON + GAP;
            else        t += d * (S_ON + GAP);
            t += PAUSE;
        end
        return t + FINAL;
    endfunction

    task automatic check(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {busy, red_led, status_led};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: busy/red/status actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic pulse_tick(input bit with_fail);
        @(negedge clk);
        ms_tick  = 1'b1;
        fail_req = with_fail;
        @(negedge clk);
        ms_tick  = 1'b0;
        fail_req = 1'b0;
    endtask

    task automatic write_code(input logic [7:0] v);
        @(negedge clk);
        code_wr_en   = 1'b1;
        code_wr_data = v;
        @(negedge clk);
        code_wr_en   = 1'b0;
        if (v != FAIL_V) model_code = int'(v);
    endtask

    task automatic start_fail(input bit via_write);
        @(negedge clk);
        if (via_write) begin
            code_wr_en   = 1'b1;
            code_wr_data = FAIL_V;
        end else begin
            fail_req = 1'b1;
        end
        @(negedge clk);
        code_wr_en = 1'b0;
        fail_req   = 1'b0;
    endtask

    // Walk one playback tick by tick; inject ignored reports and writes if asked.
    task automatic run_trace(input string tag, input int code, input bit inject);
        int total;
        int last;
        bit inj_fail;
        total = total_len(code);
        last  = total + 3 * BLINK;
        for (int s = 0; s <= last; s++) begin
            check(tag, exp_slot(code, s));
            if (s == last) break;
            inj_fail = 1'b0;
            if (inject && s < total) begin
                if ($urandom % 5 == 0) begin
                    // R3: write during playback must not alter the shown code
                    // R10 / R2: a failure-value write while busy is ignored
                    write_code(($urandom % 3 == 0) ? FAIL_V : 8'($urandom % 255));
                end
                inj_fail = ($urandom % 4 == 0); // R10 on tick cycles
            end
            pulse_tick(inj_fail);
            repeat ($urandom % 3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        int snap;
        logic [7:0] dir_codes [6];
        seed_init = $urandom(32'd20240611);
        dir_codes[0] = 8'd124; dir_codes[1] = 8'd25; dir_codes[2] = 8'd7;
        dir_codes[3] = 8'd200; dir_codes[4] = 8'd254; dir_codes[5] = 8'd1;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", 3'b000);
        pulse_tick(1'b0);
        pulse_tick(1'b0);
        check("R1 idle ticks", 3'b000);

        // R1: stored code is zero, so three long flashes (R5)
        start_fail(1'b0);
        run_trace("R1 R5 R7 R8 zero code", 0, 1'b0);

        // Directed digits: 4,4,4 / 1,0,0 / 0,1,2 / 3,0,0 / 0,0,4 / 0,0,1 (R4 R6)
        for (int i = 0; i < 6; i++) begin
            write_code(dir_codes[i]);
            check("R2 write while blinking keeps outputs idle", {1'b0, red_led, 1'b0});
            snap = model_code;
            start_fail(i[0]);
            check("R11 restart from blinking", {2'b11, status_led});
            run_trace("R4 R6 R7 R9 directed", snap, 1'b0);
        end

        // R2: failure-value write keeps stored code and starts playback
        write_code(8'd42);
        snap = model_code;
        start_fail(1'b1);
        run_trace("R2 failure value not stored", snap, 1'b0);
        start_fail(1'b0);
        run_trace("R2 stored code kept", snap, 1'b0);

        // Random codes with ignored reports and writes during playback
        for (int i = 0; i < 8; i++) begin
            write_code(8'($urandom % 255));
            snap = model_code;
            start_fail($urandom % 2 == 0);
            run_trace("R3 R10 random with injection", snap, 1'b1);
        end

        // R3: code written during the last playback is shown next time
        snap = model_code;
        start_fail(1'b0);
        run_trace("R3 later write shown next", snap, 1'b0);

        // R1: reset in the middle of playback clears everything
        write_code(8'd99);
        start_fail(1'b0);
        pulse_tick(1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset mid playback", 3'b000);
        model_code = 0;
        start_fail(1'b0);
        run_trace("R1 code cleared by reset", 0, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule